// File: doc/BRIEF.md
# Disturb-Based Cell Recovery Classifier

This block comes into play after a page read has failed ECC. Each cell on the page has two threshold-voltage snapshots: one taken before a deliberate burst of read disturbs on the page and one taken after it. The block uses the pair to decide again, between the erased state and the first programmed state, every cell whose first snapshot sits close to the read reference. A cell near the reference that moves a long way under disturb is prone to disturb, so it is taken to be erased. A cell that barely moves resists disturb, so it is taken to be programmed. Every other cell keeps the bit that was read from it.

The block also sequences the recovery. The start signal is the uncorrectable-error flag. The block then waits until the rest of the faulty block has been backed up, and after that it issues a parameterised number of disturb requests to the array. Next it opens a compare phase and takes in a stream of cell records, each carrying the before value, the after value and the raw bit. For each record it returns a corrected bit. It keeps a count of the cells whose bit it flipped and of the cells that sat exactly on the shift threshold. When it has handled the last record it pulses done.

Top module: `dcr_classifier`

## Requirements
- R1: A sequence starts only when `uncorr_i` is seen while the block is idle. A record presented outside the compare phase (`rec_ready_o` low) produces no output bit.
- R2: `disturb_req_o` stays low until `backup_done_i` has been seen after the trigger.
- R3: The disturb phase keeps `disturb_req_o` high until exactly DISTURB_N cycles have had `disturb_ack_i` high. In the cycle after the last acknowledge, `disturb_req_o` is low and `rec_ready_o` is high. The two are never high together.
- R4: A cell is susceptible only when vref − sigma < before < vref + sigma, both bounds strict. With sigma = 0 no cell is susceptible.
- R5: The shift is after − before when after > before and 0 otherwise. A susceptible cell whose shift is strictly greater than the threshold gets bit 1 (erased).
- R6: A susceptible cell whose shift is at most the threshold gets bit 0 (programmed). If its shift equals the threshold exactly, it also adds one to `amb_cnt_o`.
- R7: A cell outside the window outputs its raw bit unchanged, whatever its shift.
- R8: `flip_cnt_o` counts the susceptible cells whose decided bit differs from the raw bit. Both counters clear on a new trigger and never step by more than one per cycle.
- R9: A record accepted at a clock edge gives `bit_valid_o`/`bit_o` after the next edge. `done_o` is high for exactly one cycle, together with the result of the last record, and the block is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uncorr_i | input | 1 | Uncorrectable-read flag that starts recovery |
| backup_done_i | input | 1 | Block backup finished |
| disturb_req_o | output | 1 | Disturb read request to the array |
| disturb_ack_i | input | 1 | Array accepted one disturb read |
| vref_i | input | VW | Read reference level |
| sigma_i | input | VW | Half-width of the susceptibility window |
| shift_thr_i | input | VW | Shift threshold |
| rec_ready_o | output | 1 | Compare phase open; records accepted |
| cell_valid_i | input | 1 | Cell record valid |
| cell_before_i | input | VW | Threshold snapshot before disturb |
| cell_after_i | input | VW | Threshold snapshot after disturb |
| cell_raw_i | input | 1 | Bit as originally read |
| cell_last_i | input | 1 | Last record of the page |
| bit_valid_o | output | 1 | Corrected bit valid |
| bit_o | output | 1 | Corrected bit (1 erased, 0 programmed) |
| flip_cnt_o | output | CW | Cells flipped |
| amb_cnt_o | output | CW | Susceptible cells with shift equal to threshold |
| done_o | output | 1 | One-cycle pulse with the last result |

## Verification
A request raised at an edge is visible one cycle later. The disturb phase is therefore driven and observed at falling edges, with the acknowledges counted only in cycles where a request was seen, and the bench checks that the request has dropped in the cycle after the final acknowledge. A corrected bit is due one cycle after its record is accepted. The driver queues each expected bit as it presents the record, and the monitor takes one from the queue on every falling edge where `bit_valid_o` is high. The counters and `done_o` are checked on the falling edge that follows the last record, and `done_o` is checked once more one cycle later to confirm that it has gone low.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BKP  = 2'd1,
    ST_DIST = 2'd2,
    ST_CMP  = 2'd3
  } dcr_state_e;

  typedef struct packed {
    logic bit_v;
    logic susc;
    logic flip;
    logic tie;
  } dcr_verdict_t;
endpackage

// File: rtl/dcr_seq.sv
module dcr_seq
  import dcr_pkg::*;
#(
  parameter int unsigned DISTURB_N = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uncorr_i,
  input  logic backup_done_i,
  input  logic disturb_ack_i,
  input  logic last_acc_i,
  output logic disturb_req_o,
  output logic cmp_phase_o,
  output logic start_o
);
  localparam int unsigned DW = $clog2(DISTURB_N + 1);

  dcr_state_e    state_q, state_d;
  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (uncorr_i) begin
        state_d = ST_BKP;
        start_o = 1'b1;
      end
      ST_BKP: if (backup_done_i) begin
        state_d = ST_DIST;
        cnt_d   = DW'(DISTURB_N);
      end
      ST_DIST: if (disturb_ack_i) begin
        if (cnt_q == DW'(1)) state_d = ST_CMP;
        cnt_d = cnt_q - DW'(1);
      end
      ST_CMP: if (last_acc_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign disturb_req_o = (state_q == ST_DIST);
  assign cmp_phase_o   = (state_q == ST_CMP);
endmodule

// File: rtl/dcr_cell_eval.sv
module dcr_cell_eval
  import dcr_pkg::*;
#(
  parameter int unsigned VW = 8
) (
  input  logic [VW-1:0] before_i,
  input  logic [VW-1:0] after_i,
  input  logic          raw_i,
  input  logic [VW-1:0] vref_i,
  input  logic [VW-1:0] sigma_i,
  input  logic [VW-1:0] thr_i,
  output dcr_verdict_t  verdict_o
);
  localparam int unsigned EW = VW + 1;

  logic [EW-1:0] lo_sum, hi_sum, b_ext, r_ext;
  logic [VW-1:0] shift;
  logic          susc, big;

  // window compared without subtraction so no underflow
  assign b_ext  = {1'b0, before_i};
  assign r_ext  = {1'b0, vref_i};
  assign lo_sum = b_ext + {1'b0, sigma_i};
  assign hi_sum = r_ext + {1'b0, sigma_i};
  assign susc   = (lo_sum > r_ext) && (b_ext < hi_sum);

  assign shift = (after_i > before_i) ? (after_i - before_i) : '0;
  assign big   = (shift > thr_i);

  always_comb begin
    verdict_o.susc  = susc;
    verdict_o.bit_v = susc ? big : raw_i;
    verdict_o.flip  = susc && (big != raw_i);
    verdict_o.tie   = susc && (shift == thr_i);
  end
endmodule

// File: rtl/dcr_tally.sv
module dcr_tally
  import dcr_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         acc_i,
  input  logic         last_i,
  input  dcr_verdict_t verdict_i,
  output logic         bit_valid_o,
  output logic         bit_o,
  output logic         done_o,
  output logic [CW-1:0] flip_cnt_o,
  output logic [CW-1:0] amb_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
      done_o      <= 1'b0;
      flip_cnt_o  <= '0;
      amb_cnt_o   <= '0;
    end else begin
      bit_valid_o <= acc_i;
      done_o      <= acc_i && last_i;
      if (acc_i) bit_o <= verdict_i.bit_v;
      if (clr_i) begin
        flip_cnt_o <= '0;
        amb_cnt_o  <= '0;
      end else if (acc_i) begin
        if (verdict_i.flip && flip_cnt_o != '1) flip_cnt_o <= flip_cnt_o + CW'(1);
        if (verdict_i.tie && amb_cnt_o != '1)   amb_cnt_o  <= amb_cnt_o + CW'(1);
      end
    end
  end
endmodule

// File: rtl/dcr_classifier.sv
module dcr_classifier
  import dcr_pkg::*;
#(
  parameter int unsigned VW        = 8,
  parameter int unsigned CW        = 16,
  parameter int unsigned DISTURB_N = 100000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          uncorr_i,
  input  logic          backup_done_i,
  output logic          disturb_req_o,
  input  logic          disturb_ack_i,
  input  logic [VW-1:0] vref_i,
  input  logic [VW-1:0] sigma_i,
  input  logic [VW-1:0] shift_thr_i,
  output logic          rec_ready_o,
  input  logic          cell_valid_i,
  input  logic [VW-1:0] cell_before_i,
  input  logic [VW-1:0] cell_after_i,
  input  logic          cell_raw_i,
  input  logic          cell_last_i,
  output logic          bit_valid_o,
  output logic          bit_o,
  output logic [CW-1:0] flip_cnt_o,
  output logic [CW-1:0] amb_cnt_o,
  output logic          done_o
);
  logic         acc, start;
  dcr_verdict_t verdict;

  assign acc = cell_valid_i && rec_ready_o;

  dcr_seq #(.DISTURB_N(DISTURB_N)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .uncorr_i      (uncorr_i),
    .backup_done_i (backup_done_i),
    .disturb_ack_i (disturb_ack_i),
    .last_acc_i    (acc && cell_last_i),
    .disturb_req_o (disturb_req_o),
    .cmp_phase_o   (rec_ready_o),
    .start_o       (start)
  );

  dcr_cell_eval #(.VW(VW)) u_eval (
    .before_i  (cell_before_i),
    .after_i   (cell_after_i),
    .raw_i     (cell_raw_i),
    .vref_i    (vref_i),
    .sigma_i   (sigma_i),
    .thr_i     (shift_thr_i),
    .verdict_o (verdict)
  );

  dcr_tally #(.CW(CW)) u_tally (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start),
    .acc_i       (acc),
    .last_i      (cell_last_i),
    .verdict_i   (verdict),
    .bit_valid_o (bit_valid_o),
    .bit_o       (bit_o),
    .done_o      (done_o),
    .flip_cnt_o  (flip_cnt_o),
    .amb_cnt_o   (amb_cnt_o)
  );
endmodule

// File: rtl/dcr_classifier_chk.sv
module dcr_classifier_chk #(
  parameter int unsigned VW = 8,
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          backup_done_i,
  input logic          disturb_req_o,
  input logic          rec_ready_o,
  input logic          cell_valid_i,
  input logic [VW-1:0] cell_before_i,
  input logic [VW-1:0] vref_i,
  input logic [VW-1:0] sigma_i,
  input logic          cell_raw_i,
  input logic          bit_valid_o,
  input logic          bit_o,
  input logic [CW-1:0] flip_cnt_o,
  input logic          done_o
);
  logic outside;
  assign outside = ({1'b0, cell_before_i} + {1'b0, sigma_i} <= {1'b0, vref_i}) ||
                   ({1'b0, cell_before_i} >= {1'b0, vref_i} + {1'b0, sigma_i});

  AST_REQ_AFTER_BACKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disturb_req_o) |-> $past(backup_done_i)); // R2
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(disturb_req_o && rec_ready_o)); // R3
  AST_OUT_FROM_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $past(cell_valid_i && rec_ready_o)); // R1
  AST_KEEP_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_i && rec_ready_o && outside) |=> (bit_o == $past(cell_raw_i))); // R7
  AST_FLIP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_cnt_o != $past(flip_cnt_o)) |->
      (flip_cnt_o == $past(flip_cnt_o) + CW'(1) || flip_cnt_o == '0)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_WITH_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bit_valid_o); // R9
endmodule

bind dcr_classifier dcr_classifier_chk #(.VW(VW), .CW(CW)) u_chk (.*);

// File: tb/dcr_classifier_tb.sv
module dcr_classifier_tb;
  localparam int CLK_P = 10;
  localparam int VW = 8;
  localparam int CW = 16;
  localparam int DN = 20;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic uncorr_i = 0, backup_done_i = 0, disturb_ack_i = 0;
  logic [VW-1:0] vref_i = 0, sigma_i = 0, shift_thr_i = 0;
  logic cell_valid_i = 0, cell_raw_i = 0, cell_last_i = 0;
  logic [VW-1:0] cell_before_i = 0, cell_after_i = 0;
  logic disturb_req_o, rec_ready_o, bit_valid_o, bit_o, done_o;
  logic [CW-1:0] flip_cnt_o, amb_cnt_o;

  int total = 0, bad = 0;
  bit exp_q[$];

  always #(CLK_P/2) clk_i = ~clk_i;

  dcr_classifier #(.VW(VW), .CW(CW), .DISTURB_N(DN)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model(input int b, input int a, input bit raw,
                               input int v, input int s, input int t);
    int sh;
    if (!(b > v - s && b < v + s)) return raw;  // R7
    sh = (a > b) ? a - b : 0;
    return (sh > t);                            // R5 / R6
  endfunction

  task automatic send(input int b, input int a, input bit raw, input bit last);
    @(negedge clk_i);
    cell_valid_i = 1; cell_before_i = VW'(b); cell_after_i = VW'(a);
    cell_raw_i = raw; cell_last_i = last;
    exp_q.push_back(model(b, a, raw, int'(vref_i), int'(sigma_i), int'(shift_thr_i)));
  endtask

  task automatic hush();
    @(negedge clk_i);
    cell_valid_i = 0; cell_last_i = 0;
  endtask

  // monitor: one expected bit per valid output
  always @(negedge clk_i) begin
    if (rst_ni && bit_valid_o) begin
      if (exp_q.size() == 0) chk("R1 unexpected bit", 1, 0);
      else chk("R5/R6/R7 bit", int'(bit_o), int'(exp_q.pop_front()));
    end
  end

  task automatic start_and_disturb();
    int acks;
    @(negedge clk_i); uncorr_i = 1;
    @(negedge clk_i); uncorr_i = 0;
    chk("R8 counters cleared", int'(flip_cnt_o) + int'(amb_cnt_o), 0);
    repeat (4) begin
      @(negedge clk_i);
      chk("R2 no req before backup", int'(disturb_req_o), 0);
    end
    backup_done_i = 1;
    @(negedge clk_i); backup_done_i = 0;
    acks = 0;
    for (int i = 0; i < 200 && disturb_req_o; i++) begin
      disturb_ack_i = (i % 3 != 2);
      if (disturb_ack_i) acks++;
      @(negedge clk_i);
    end
    disturb_ack_i = 0;
    chk("R3 acked disturbs", acks, DN);
    chk("R3 req low after last ack", int'(disturb_req_o), 0);
    chk("R3 compare phase open", int'(rec_ready_o), 1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R9 reset bit_valid", int'(bit_valid_o), 0);
    chk("R9 reset done", int'(done_o), 0);
    chk("R3 reset req", int'(disturb_req_o), 0);
    chk("R1 reset ready", int'(rec_ready_o), 0);

    // R1: record while idle is ignored
    vref_i = 100; sigma_i = 10; shift_thr_i = 20;
    @(negedge clk_i);
    cell_valid_i = 1; cell_before_i = 95; cell_after_i = 200;
    @(negedge clk_i);
    cell_valid_i = 0;
    @(negedge clk_i);
    chk("R1 idle record no output", int'(bit_valid_o), 0);
    chk("R1 no start without trigger", int'(disturb_req_o) + int'(rec_ready_o), 0);

    start_and_disturb();
    send(95, 130, 0, 0);   // R5 big shift -> 1, flip
    send(105, 110, 1, 0);  // R6 small -> 0, flip
    send(100, 120, 0, 0);  // R6 tie -> 0, ambiguous
    send(90, 200, 1, 0);   // R4 lower bound excluded, kept
    send(110, 111, 0, 0);  // R4 upper bound excluded, kept
    send(91, 80, 1, 0);    // R5 negative shift saturates -> 0, flip
    send(109, 200, 1, 0);  // R5 -> 1, no flip
    send(30, 255, 0, 1);   // R7 outside, kept
    hush();
    chk("R9 done with last", int'(done_o), 1);
    chk("R8 flip count", int'(flip_cnt_o), 3);
    chk("R6 ambiguous count", int'(amb_cnt_o), 1);
    @(negedge clk_i);
    chk("R9 done one cycle", int'(done_o), 0);
    chk("R9 back to idle", int'(rec_ready_o), 0);

    // second page: empty window
    vref_i = 50; sigma_i = 0; shift_thr_i = 0;
    start_and_disturb();
    send(50, 90, 1, 0);    // R4 sigma zero, kept
    hush();
    send(49, 200, 0, 0);
    send(51, 51, 1, 1);
    hush();
    chk("R9 done second page", int'(done_o), 1);
    chk("R8 flips after clear", int'(flip_cnt_o), 0);
    chk("R8 amb after clear", int'(amb_cnt_o), 0);
    @(negedge clk_i);
    chk("R9 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule